// File: doc/BRIEF.md
# Eight-Bit GPIO Port with Pin Readback

This block is one general purpose I/O port of eight pins, reached over a plain synchronous register bus. Software owns three views of the port: an output-value register, a per-pin direction register, and a read-only input view that always reports the synchronized pin levels. A read of the output-value address merges the two sources bit by bit. A pin configured as an output returns the value that was written. A pin configured as an input returns the level seen on the pin.

Each pin can also be lent to an external peripheral channel with the same index, such as a timer capture/compare line, through a per-bit claim input. A claimed pin takes its drive value and drive enable from the peripheral instead of from the port registers. The peripheral always receives the synchronized pin levels.

Because the input view ignores the direction setting, software can compare it against the written value to detect a pin that is shorted or overloaded while it is being driven.

Top module: `gpio_readback_port`

## Requirements
- R1: While `rst_n` is low, `rd_data`, `pin_out` and `pin_oe` are all zero, and the output-value and direction registers are cleared, so every unclaimed pin is an undriven input after reset.
- R2: A write with `wr_en` high takes effect at the clock edge. Address 0 selects the output-value register and address 1 selects the direction register. Both registers can be written and read at any time, and `rd_data` is registered: it shows the selected register one clock after the address is presented.
- R3: A read of address 0 returns, for each bit n, the written value when direction bit n is 1, and the synchronized level of pin n when direction bit n is 0.
- R4: A read of address 2 returns the synchronized level of every pin, whatever the direction bits are.
- R5: Writes to address 2 (the input view) and to address 3 (unused) change no register and have no other effect. Address 3 reads as zero.
- R6: Pin levels pass through two bus-clock flops. A pin change made between two edges is first returned by a read of address 2 held steady at the third following edge. After the first two edges the read still shows the old level.
- R7: For a pin whose claim bit in `alt_en` is 0, `pin_out` carries the written value bit and `pin_oe` carries the direction bit.
- R8: For a pin whose claim bit in `alt_en` is 1, `pin_out` and `pin_oe` carry `alt_out` and `alt_oe` for that bit. The port's value and direction bits for that pin then have no effect on the pad.
- R9: `alt_in` always carries the synchronized pin levels, the same values that address 2 returns.
- R10: After `rst_n` rises, a read of address 2 held steady returns zero at the first and second edges. It returns the pin levels from the third edge on.
- R11: When a pin driven as an output is forced to the opposite level, address 2 reports the forced level and address 0 still reports the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address: 0 value, 1 direction, 2 input view, 3 unused |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| pin_out | output | 8 | Drive value to the pads |
| pin_oe | output | 8 | Drive enable to the pads, 1 drives |
| alt_en | input | 8 | Per-pin claim by the peripheral channel |
| alt_out | input | 8 | Peripheral drive value |
| alt_oe | input | 8 | Peripheral drive enable |
| alt_in | output | 8 | Synchronized pin levels for the peripheral |

## Verification
The bench targets the gaps between reset release and valid pin data, and between a pin change and its readback. A design with one synchronizer flop too few, or one too many, returns the new level an edge early or an edge late. The short-circuit case drives all pins high and forces some of them low. A design that feeds the latch into the input view, or the pin into an output bit of the value read, then reports the wrong side. Writes aimed at the read-only and unused addresses are checked for leaks into the value and direction registers. Claimed pins are given port settings that conflict with the peripheral's, so a mux that selects the wrong source shows up on `pin_out` or `pin_oe`.

// File: rtl/gpio_rb_pkg.sv
// Package gpio_rb_pkg
// Shared address map for the readback GPIO port. The encodings are fixed
// because software and the bench rely on them.
package gpio_rb_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_VALUE = 2'd0,
        ADDR_DIR   = 2'd1,
        ADDR_PINS  = 2'd2,
        ADDR_SPARE = 2'd3
    } gpio_addr_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module gpio_pin_sync
// Multi-flop synchronizer that brings asynchronous pad levels into the bus
// clock domain. Assumes each bit is independent: no cross-bit coherence is
// promised. All stages clear on synchronous active-low reset.
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int AGE_W = $clog2(STAGES + 1);

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pad levels in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= async_i;
                end
            end else begin : g_next
                // Shift the levels one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];

    // Count edges since reset release, saturating once the chain is full.
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          age_q <= '0;
        else if (age_q != AGE_W'(STAGES))    age_q <= age_q + 1'b1;
    end

    // R6
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AGE_W'(STAGES)) |-> (sync_o == $past(async_i, STAGES)));
endmodule

// File: rtl/gpio_regs.sv
// Module gpio_regs
// Holds the output-value and direction registers and decodes bus writes.
// Assumes one write per cycle. Writes to the input view and the spare
// address are dropped.
module gpio_regs
    import gpio_rb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [WIDTH-1:0]  wr_data_i,
    output logic [WIDTH-1:0]  value_o,
    output logic [WIDTH-1:0]  dir_o
);
    logic [WIDTH-1:0] value_q;
    logic [WIDTH-1:0] dir_q;
    logic             hit_value;
    logic             hit_dir;

    // Decode which writable register, if any, the current write targets.
    always_comb begin
        hit_value = wr_en_i && (addr_i == ADDR_VALUE);
        hit_dir   = wr_en_i && (addr_i == ADDR_DIR);
    end

    // Update the output-value register on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)         value_q <= '0;
        else if (hit_value) value_q <= wr_data_i;
    end

    // Update the direction register on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= '0;
        else if (hit_dir) dir_q <= wr_data_i;
    end

    assign value_o = value_q;
    assign dir_o   = dir_q;

    // R2
    value_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_VALUE) |=> (value_q == $past(wr_data_i)));

    // R5
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (addr_i == ADDR_PINS || addr_i == ADDR_SPARE))
        |=> ($stable(value_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_pad_mux.sv
// Module gpio_pad_mux
// Per-pin selection of drive value and drive enable between the port
// registers and the peripheral channel of the same index. Purely
// combinational; assumes the claim bits are already stable in the bus domain.
module gpio_pad_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] claim_i,
    input  logic [WIDTH-1:0] port_val_i,
    input  logic [WIDTH-1:0] port_dir_i,
    input  logic [WIDTH-1:0] per_val_i,
    input  logic [WIDTH-1:0] per_oe_i,
    output logic [WIDTH-1:0] pad_val_o,
    output logic [WIDTH-1:0] pad_oe_o
);
    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_pin
            // Route this pin's drive from the peripheral when it is claimed.
            always_comb begin
                if (claim_i[b]) begin
                    pad_val_o[b] = per_val_i[b];
                    pad_oe_o[b]  = per_oe_i[b];
                end else begin
                    pad_val_o[b] = port_val_i[b];
                    pad_oe_o[b]  = port_dir_i[b];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_read_mux.sv
// Module gpio_read_mux
// Selects the read source for the current address and registers it, so read
// data is valid one cycle after the address. The value address merges the
// latch and the pin levels per bit according to direction.
module gpio_read_mux
    import gpio_rb_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  value_i,
    input  logic [WIDTH-1:0]  dir_i,
    input  logic [WIDTH-1:0]  pins_i,
    output logic [WIDTH-1:0]  rd_data_o
);
    logic [WIDTH-1:0] merged;
    logic [WIDTH-1:0] rd_next;
    logic [WIDTH-1:0] rd_q;

    // Per bit, take the latch for outputs and the pin for inputs.
    always_comb begin
        merged = (value_i & dir_i) | (pins_i & ~dir_i);
    end

    // Pick the read source for the presented address.
    always_comb begin
        unique case (addr_i)
            ADDR_VALUE: rd_next = merged;
            ADDR_DIR:   rd_next = dir_i;
            ADDR_PINS:  rd_next = pins_i;
            default:    rd_next = '0;
        endcase
    end

    // Register the read data; clear it while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_next;
    end

    assign rd_data_o = rd_q;

    // R4
    pin_view_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_PINS) |=> (rd_q == $past(pins_i)));

    // R3
    value_view_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_VALUE) |=>
        (rd_q == (($past(value_i) & $past(dir_i)) | ($past(pins_i) & ~$past(dir_i)))));

    // R5
    spare_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_SPARE) |=> (rd_q == '0));
endmodule

// File: rtl/gpio_readback_port.sv
// Module gpio_readback_port
// Eight-pin GPIO port: registers, pin synchronizer, pad mux toward a
// peripheral channel, and registered readback. Assumes a single bus clock and
// synchronous active-low reset; pad electronics are outside.
module gpio_readback_port
    import gpio_rb_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    input  logic [WIDTH-1:0]  alt_en,
    input  logic [WIDTH-1:0]  alt_out,
    input  logic [WIDTH-1:0]  alt_oe,
    output logic [WIDTH-1:0]  alt_in
);
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] value_reg;
    logic [WIDTH-1:0] dir_reg;

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pins_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .value_o   (value_reg),
        .dir_o     (dir_reg)
    );

    gpio_pad_mux #(.WIDTH(WIDTH)) u_pad (
        .claim_i    (alt_en),
        .port_val_i (value_reg),
        .port_dir_i (dir_reg),
        .per_val_i  (alt_out),
        .per_oe_i   (alt_oe),
        .pad_val_o  (pin_out),
        .pad_oe_o   (pin_oe)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .value_i   (value_reg),
        .dir_i     (dir_reg),
        .pins_i    (pins_sync),
        .rd_data_o (rd_data)
    );

    assign alt_in = pins_sync;

    // R1
    reset_drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n)) |-> ((pin_oe & ~alt_en) == '0));

    // R7
    unclaimed_dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DIR && alt_en == '0 && $stable(alt_en))
        |=> (pin_oe == $past(wr_data)));
endmodule

// File: tb/gpio_readback_port_bench.sv
// Module gpio_readback_port_bench
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a bench-side model of the register state.
module gpio_readback_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   addr;
    logic         wr_en;
    logic [W-1:0] wr_data;
    logic [W-1:0] rd_data;
    logic [W-1:0] pin_in;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;
    logic [W-1:0] alt_en;
    logic [W-1:0] alt_out;
    logic [W-1:0] alt_oe;
    logic [W-1:0] alt_in;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_value;
    logic [W-1:0] m_dir;
    logic [W-1:0] m_pins;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_readback_port u_gpio_readback_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_en(alt_en),
        .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
    );

    function automatic logic [W-1:0] exp_value_read(logic [W-1:0] v, logic [W-1:0] d, logic [W-1:0] p);
        return (v & d) | (p & ~d);
    endfunction

    function automatic logic [W-1:0] exp_pad(logic [W-1:0] c, logic [W-1:0] port, logic [W-1:0] per);
        return (per & c) | (port & ~c);
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [W-1:0] d);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd0) m_value = d;
        if (a == 2'd1) m_dir   = d;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [W-1:0] r);
        addr = a; wr_en = 1'b0;
        @(negedge clk);
        r = rd_data;
    endtask

    task automatic set_pins(input logic [W-1:0] v);
        pin_in = v;
        @(negedge clk);
        @(negedge clk);
        m_pins = v;
    endtask

    task automatic check_pads(input string req);
        logic [W-1:0] eo;
        logic [W-1:0] ee;
        eo = exp_pad(alt_en, m_value, alt_out);
        ee = exp_pad(alt_en, m_dir, alt_oe);
        check(pin_out == eo, req, pin_out, eo);
        check(pin_oe == ee, req, pin_oe, ee);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] r;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; addr = 2'd2; wr_en = 1'b0; wr_data = '0;
        pin_in = 8'hA5; alt_en = '0; alt_out = '0; alt_oe = '0;
        m_value = '0; m_dir = '0; m_pins = '0;

        // R1: outputs quiet during reset even with pins active
        repeat (4) @(negedge clk);
        check(rd_data == 8'h00, "R1", rd_data, 8'h00);
        check(pin_oe == 8'h00, "R1", pin_oe, 8'h00);
        check(pin_out == 8'h00, "R1", pin_out, 8'h00);

        // R10: readback of pins lags reset release by three edges
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 8'h00, "R10", rd_data, 8'h00);
        @(negedge clk);
        check(rd_data == 8'h00, "R10", rd_data, 8'h00);
        @(negedge clk);
        check(rd_data == 8'hA5, "R10", rd_data, 8'hA5);
        m_pins = 8'hA5;
        do_read(2'd1, r);
        check(r == 8'h00, "R1", r, 8'h00);

        // R6: synchronizer latency on a pin change, address held
        addr = 2'd2;
        @(negedge clk);
        pin_in = 8'h3C;
        @(negedge clk);
        check(rd_data == 8'hA5, "R6", rd_data, 8'hA5);
        @(negedge clk);
        check(rd_data == 8'hA5, "R6", rd_data, 8'hA5);
        @(negedge clk);
        check(rd_data == 8'h3C, "R6", rd_data, 8'h3C);
        m_pins = 8'h3C;
        check(alt_in == 8'h3C, "R9", alt_in, 8'h3C);

        // R2 / R3: direction mix on value read
        do_write(2'd1, 8'hF0);
        do_write(2'd0, 8'h5A);
        do_read(2'd1, r);
        check(r == 8'hF0, "R2", r, 8'hF0);
        do_read(2'd0, r);
        check(r == exp_value_read(8'h5A, 8'hF0, 8'h3C), "R3", r, exp_value_read(8'h5A, 8'hF0, 8'h3C));
        do_read(2'd2, r);
        check(r == 8'h3C, "R4", r, 8'h3C);
        check_pads("R7");

        // R11: driven outputs forced to the opposite level
        do_write(2'd1, 8'hFF);
        do_write(2'd0, 8'hFF);
        set_pins(8'h0F);
        do_read(2'd2, r);
        check(r == 8'h0F, "R11", r, 8'h0F);
        do_read(2'd0, r);
        check(r == 8'hFF, "R11", r, 8'hFF);
        check(pin_out == 8'hFF && pin_oe == 8'hFF, "R11", pin_out & pin_oe, 8'hFF);

        // R5: writes to input view and spare address leave state alone
        do_write(2'd2, 8'h55);
        do_write(2'd3, 8'hAA);
        do_read(2'd0, r);
        check(r == 8'hFF, "R5", r, 8'hFF);
        do_read(2'd1, r);
        check(r == 8'hFF, "R5", r, 8'hFF);
        do_read(2'd2, r);
        check(r == 8'h0F, "R5", r, 8'h0F);
        do_read(2'd3, r);
        check(r == 8'h00, "R5", r, 8'h00);
        check_pads("R5");

        // R8: claimed pins follow the peripheral despite conflicting port bits
        do_write(2'd1, 8'h0F);
        do_write(2'd0, 8'h33);
        alt_en = 8'hF0; alt_out = 8'hAA; alt_oe = 8'hCC;
        @(negedge clk);
        check(pin_out == 8'hA3, "R8", pin_out, 8'hA3);
        check(pin_oe == 8'hCF, "R8", pin_oe, 8'hCF);
        check(alt_in == m_pins, "R9", alt_in, m_pins);

        // Random traffic against the model
        for (int i = 0; i < 300; i++) begin
            int unsigned op;
            logic [1:0] a;
            op = $urandom_range(0, 3);
            a  = 2'($urandom_range(0, 3));
            case (op)
                0: do_write(a, W'($urandom));
                1: set_pins(W'($urandom));
                2: begin
                    alt_en = W'($urandom); alt_out = W'($urandom); alt_oe = W'($urandom);
                    @(negedge clk);
                end
                default: ;
            endcase
            check_pads(alt_en == '0 ? "R7" : "R8");
            check(alt_in == m_pins, "R9", alt_in, m_pins);
            do_read(a, r);
            case (a)
                2'd0: check(r == exp_value_read(m_value, m_dir, m_pins), "R3", r, exp_value_read(m_value, m_dir, m_pins));
                2'd1: check(r == m_dir, "R2", r, m_dir);
                2'd2: check(r == m_pins, "R4", r, m_pins);
                default: check(r == 8'h00, "R5", r, 8'h00);
            endcase
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule